// File: doc/BRIEF.md
# Camp-On Connection Request Transmitter

This block sits in the transmit path of a port card that reaches a switch fabric over a serial backplane. An upstream word source feeds it under control of a read enable. When that source offers a connection request word, the block takes it and stops reading. It then sends the request to the switch over and over until the switch answers with an acknowledge. A 3-bit spacing code sets how many idle words go between two copies of the request. Requests that come more often win arbitration more often, so the spacing code acts as a priority.

Once the acknowledge arrives, an optional post-grant delay of a programmable number of cycles may follow. After that the block reads again. It forwards the header word and then the data words of the packet until a word flagged as last has gone out. A built-in floor keeps the read enable low for at least 9 cycles after a request is loaded. This holds even if the grant comes back at once. Every outgoing word carries a 2-bit type code: idle 0, request 1, header 2, data 3.

Top module: `campon_tx`

## Requirements
- R1: After reset, rd_en_o is 1, wait_o is 0, type_o is 0 (idle) and word_o is 0.
- R2: In the cycle after a word of type 1 (request) is read while idle (rd_en_o high), rd_en_o is 0 and wait_o is 1.
- R3: While waiting for a grant, the block emits the captured request word with type 1. The first copy appears in the cycle right after loading.
- R4: After each request word with no acknowledge, exactly gap_i idle words (type 0) follow before the next request word. gap_i is read as unsigned (0 to 7) in the cycle the request word is emitted.
- R5: An acknowledge seen during a request or idle-gap cycle with delay disabled ends the repetition on the next cycle. The remaining idles are dropped and the header phase starts.
- R6: With dly_en_i high and dly_n_i = N > 0 at the acknowledge, N idle cycles with rd_en_o low pass before the header phase. N = 0 behaves as delay disabled.
- R7: rd_en_o rises no earlier than 9 cycles after the cycle in which the request was read.
- R8: In the header phase, a word of type 2 read with rd_en_o high appears one cycle later on word_o with type 2. wait_o is 0 from that cycle on.
- R9: During transfer, a read word of type 3 appears one cycle later with type 3 and the same value. Any other read type yields an idle output word.
- R10: A type-3 word read with eop_i high ends the packet. In the next cycle that word is on the output and rd_en_o is 0. In the cycle after that, rd_en_o is 1 and the output is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | DATA_W | Word offered by the upstream source |
| type_i | input | 2 | Type of the offered word (0 idle, 1 request, 2 header, 3 data) |
| eop_i | input | 1 | Offered data word is the last of its packet |
| gap_i | input | 3 | Idle words inserted after each request copy |
| dly_en_i | input | 1 | Enable post-acknowledge delay |
| dly_n_i | input | DLY_W | Post-acknowledge delay in cycles |
| ack_i | input | 1 | Grant from the switch |
| rd_en_o | output | 1 | Offered word is consumed at the next clock edge |
| wait_o | output | 1 | Waiting for grant (request repeat, delay, header pending) |
| word_o | output | DATA_W | Outgoing word |
| type_o | output | 2 | Type of the outgoing word |

## Verification
A request read at one edge shows on the output and drops the read enable in the very next cycle. A gap code or an acknowledge sampled at an edge sets the next cycle's word. Header and data words reach the output exactly one cycle after they are read. The read enable rises in the cycle after the last delay cycle, or at the ninth cycle after loading, whichever is later. The bench keeps a behavioural model that it advances on every rising edge from the same inputs. It compares every output at the following falling edge, so each result is checked in the cycle it is due. It also measures the idle runs between requests and the load-to-read latency directly from the ports.

// File: rtl/campon_pkg.sv
package campon_pkg;
  typedef enum logic [1:0] {
    WT_IDLE = 2'd0,
    WT_REQ  = 2'd1,
    WT_HDR  = 2'd2,
    WT_DATA = 2'd3
  } wtype_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_GAP,
    ST_DLY,
    ST_HDR,
    ST_XFER,
    ST_TAIL
  } state_e;
endpackage

// File: rtl/campon_dcnt.sv
module campon_dcnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == W'(1));

  // gap and delay runs never decrement through zero
  assert_no_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |-> (cnt_q > W'(1)));
endmodule

// File: rtl/campon_lat.sv
module campon_lat #(
  parameter int MIN_LAT = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic done_o
);
  localparam int LMAX = MIN_LAT - 1;
  localparam int LW   = $clog2(MIN_LAT + 1);

  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (cnt_q < LW'(LMAX))    cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q >= LW'(LMAX));

  // once reached, the floor stays met until the next load
  assert_lat_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_i) |=> done_o);
endmodule

// File: rtl/campon_tx.sv
module campon_tx
  import campon_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DLY_W   = 4,
  parameter int MIN_LAT = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] word_i,
  input  logic [1:0]        type_i,
  input  logic              eop_i,
  input  logic [2:0]        gap_i,
  input  logic              dly_en_i,
  input  logic [DLY_W-1:0]  dly_n_i,
  input  logic              ack_i,
  output logic              rd_en_o,
  output logic              wait_o,
  output logic [DATA_W-1:0] word_o,
  output logic [1:0]        type_o
);
  localparam int CW = (DLY_W > 3) ? DLY_W : 3;

  state_e            st_q, st_d;
  logic [DATA_W-1:0] req_q, out_w_q;
  logic [1:0]        out_t_q;
  logic              cnt_load, cnt_dec, cnt_last;
  logic [CW-1:0]     cnt_val;
  logic              lat_clr, lat_done;

  campon_dcnt #(.W(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .val_i  (cnt_val),
    .dec_i  (cnt_dec),
    .last_o (cnt_last)
  );

  campon_lat #(.MIN_LAT(MIN_LAT)) u_lat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (lat_clr),
    .done_o (lat_done)
  );

  always_comb begin
    st_d     = st_q;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    cnt_val  = '0;
    lat_clr  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (type_i == WT_REQ) begin
        st_d    = ST_REQ;
        lat_clr = 1'b1;
      end
      ST_REQ, ST_GAP: begin
        if (ack_i) begin
          // grant drops any idles left in the gap
          if (dly_en_i && dly_n_i != '0) begin
            cnt_load = 1'b1;
            cnt_val  = CW'(dly_n_i);
            st_d     = ST_DLY;
          end else begin
            st_d = ST_HDR;
          end
        end else if (st_q == ST_REQ) begin
          if (gap_i != 3'd0) begin
            cnt_load = 1'b1;
            cnt_val  = CW'(gap_i);
            st_d     = ST_GAP;
          end
        end else if (cnt_last) begin
          st_d = ST_REQ;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      ST_DLY: begin
        if (cnt_last) st_d = ST_HDR;
        else          cnt_dec = 1'b1;
      end
      ST_HDR:  if (lat_done && type_i == WT_HDR) st_d = ST_XFER;
      ST_XFER: if (type_i == WT_DATA && eop_i) st_d = ST_TAIL;
      ST_TAIL: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      req_q   <= '0;
      out_w_q <= '0;
      out_t_q <= WT_IDLE;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && type_i == WT_REQ) req_q <= word_i;
      if (st_q == ST_HDR && lat_done && type_i == WT_HDR) begin
        out_w_q <= word_i;
        out_t_q <= WT_HDR;
      end else if (st_q == ST_XFER) begin
        out_w_q <= (type_i == WT_DATA) ? word_i : '0;
        out_t_q <= (type_i == WT_DATA) ? WT_DATA : WT_IDLE;
      end
    end
  end

  assign rd_en_o = (st_q == ST_IDLE) || (st_q == ST_XFER) ||
                   (st_q == ST_HDR && lat_done);
  assign wait_o  = (st_q == ST_REQ) || (st_q == ST_GAP) ||
                   (st_q == ST_DLY) || (st_q == ST_HDR);

  always_comb begin
    unique case (st_q)
      ST_REQ:           begin word_o = req_q;   type_o = WT_REQ;  end
      ST_XFER, ST_TAIL: begin word_o = out_w_q; type_o = out_t_q; end
      default:          begin word_o = '0;      type_o = WT_IDLE; end
    endcase
  end

  assert_load_stall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && type_i == WT_REQ) |=> (!rd_en_o && wait_o));

  assert_req_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (type_o == WT_REQ) |-> (wait_o && !rd_en_o));

  assert_back_to_back_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (type_o == WT_REQ && !ack_i && gap_i == 3'd0) |=> (type_o == WT_REQ));

  assert_grant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_REQ || st_q == ST_GAP) && ack_i && !dly_en_i) |=>
      (st_q == ST_HDR && type_o == WT_IDLE));

  assert_grant_delay_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_REQ || st_q == ST_GAP) && ack_i && dly_en_i && dly_n_i != '0) |=>
      (st_q == ST_DLY && !rd_en_o));

  assert_rise_floor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rd_en_o) && wait_o) |-> lat_done);

  assert_header_out_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HDR && rd_en_o && type_i == WT_HDR) |=>
      (type_o == WT_HDR && !wait_o && word_o == $past(word_i)));

  assert_data_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_XFER && type_i == WT_DATA) |=>
      (type_o == WT_DATA && word_o == $past(word_i)));

  assert_packet_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_XFER && type_i == WT_DATA && eop_i) |=> (!rd_en_o ##1 rd_en_o));
endmodule

// File: tb/campon_tx_test.sv
`timescale 1ns/1ps
module campon_tx_test;
  localparam int DW = 32;
  localparam int NW = 4;
  localparam int ML = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [DW-1:0] d_word = '0;
  logic [1:0]    d_type = 2'd0;
  logic          d_eop  = 1'b0;
  logic [2:0]    d_gap  = 3'd0;
  logic          d_den  = 1'b0;
  logic [NW-1:0] d_n    = '0;
  logic          d_ack  = 1'b0;
  logic          rd_en_o, wait_o;
  logic [DW-1:0] word_o;
  logic [1:0]    type_o;

  campon_tx #(.DATA_W(DW), .DLY_W(NW), .MIN_LAT(ML)) uut (
    .clk_i(clk), .rst_ni(rst_n), .word_i(d_word), .type_i(d_type), .eop_i(d_eop),
    .gap_i(d_gap), .dly_en_i(d_den), .dly_n_i(d_n), .ack_i(d_ack),
    .rd_en_o(rd_en_o), .wait_o(wait_o), .word_o(word_o), .type_o(type_o)
  );

  int checks = 0, errors = 0;

  typedef struct { logic [1:0] t; logic [DW-1:0] w; logic e; } item_t;
  item_t q[$];

  // behavioural model: phase 0 idle,1 req,2 gap,3 delay,4 header,5 xfer,6 tail
  int ph = 0, left = 0, since = 0;
  logic [DW-1:0] rq = '0, ow = '0;
  logic [1:0]    ot = 2'd0;

  function automatic logic e_rd();
    return (ph == 0) || (ph == 5) || (ph == 4 && since >= ML - 1);
  endfunction
  function automatic logic e_wait();
    return (ph >= 1 && ph <= 4);
  endfunction
  function automatic logic [1:0] e_t();
    return (ph == 1) ? 2'd1 : (ph >= 5) ? ot : 2'd0;
  endfunction
  function automatic logic [DW-1:0] e_w();
    return (ph == 1) ? rq : (ph >= 5) ? ow : '0;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      bit hdr_ok;
      hdr_ok = (since >= ML - 1);
      if (since < ML) since++;
      case (ph)
        0: if (d_type == 2'd1) begin rq = d_word; ph = 1; since = 0; end
        1, 2: begin
          if (d_ack) begin
            if (d_den && d_n != 0) begin left = int'(d_n); ph = 3; end
            else ph = 4;
          end else if (ph == 1) begin
            if (d_gap != 0) begin left = int'(d_gap); ph = 2; end
          end else begin
            left--;
            if (left == 0) ph = 1;
          end
        end
        3: begin left--; if (left == 0) ph = 4; end
        4: if (hdr_ok && d_type == 2'd2) begin ot = 2'd2; ow = d_word; ph = 5; end
        5: begin
          if (d_type == 2'd3) begin
            ot = 2'd3; ow = d_word;
            if (d_eop) ph = 6;
          end else begin
            ot = 2'd0; ow = '0;
          end
        end
        6: ph = 0;
        default: ph = 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  int  cyc = 0, wcnt = 0, ack_at = 1, load_cyc = -1, idles = 0;
  bit  acked = 0, prev_rd = 0, gap_seen = 0;

  task automatic step();
    @(negedge clk);
    cyc++;
    chk(rd_en_o == e_rd(), "R2/R5/R6/R7/R10", "rd_en", rd_en_o, e_rd());
    chk(wait_o == e_wait(), "R2/R8", "wait", wait_o, e_wait());
    chk(type_o == e_t() && word_o == e_w(), "R3/R4/R5/R6/R9/R10", "type:word",
        {type_o, word_o}, {e_t(), e_w()});
    // R4: idle run between two request copies equals gap code
    if (!wait_o) gap_seen = 0;
    else if (type_o == 2'd1) begin
      if (gap_seen) chk(idles == int'(d_gap), "R4", "idle run", idles, d_gap);
      gap_seen = 1; idles = 0;
    end else if (gap_seen) idles++;
    // consumption and R7 latency floor
    if (prev_rd && q.size() > 0) begin
      if (q[0].t == 2'd1) load_cyc = cyc - 1;
      void'(q.pop_front());
    end
    if (rd_en_o && !prev_rd && load_cyc >= 0) begin
      chk(cyc - load_cyc >= ML, "R7", "load to read", cyc - load_cyc, ML);
      load_cyc = -1;
    end
    if (q.size() > 0) begin d_type = q[0].t; d_word = q[0].w; d_eop = q[0].e; end
    else begin d_type = 2'd0; d_word = '0; d_eop = 1'b0; end
    if (wait_o) wcnt++; else begin wcnt = 0; acked = 0; end
    d_ack = wait_o && !acked && (wcnt == ack_at);
    if (d_ack) acked = 1;
    prev_rd = rd_en_o;
  endtask

  task automatic pkt(input logic [DW-1:0] base, input int nd, input bit bubble);
    q.push_back('{2'd1, base, 1'b0});
    q.push_back('{2'd2, base + 32'h100, 1'b0});
    for (int i = 0; i < nd; i++) begin
      if (bubble && i == 1) q.push_back('{2'd0, 32'hdead, 1'b0});
      q.push_back('{2'd3, base + 32'h200 + i, (i == nd - 1)});
    end
  endtask

  task automatic run(input string tag);
    int quiet = 0, n = 0;
    while (quiet < 3 && n < 400) begin
      step();
      n++;
      if (q.size() == 0 && ph == 0) quiet++; else quiet = 0;
    end
    chk(n < 400, tag, "scenario completes", n, 400);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL all: watchdog expired, actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_en_o == 1'b1 && wait_o == 1'b0, "R1", "rd/wait", {rd_en_o, wait_o}, 2'b10);
    chk(type_o == 2'd0 && word_o == '0, "R1", "out", {type_o, word_o}, 0);
    rst_n = 1'b1;
    // R4 gap 2, grant on a request copy
    d_gap = 3'd2; ack_at = 7; pkt(32'hA000_0000, 3, 0); run("R4");
    // R5 R7 back-to-back requests, immediate grant: floor governs
    d_gap = 3'd0; ack_at = 1; pkt(32'hB000_0000, 2, 0); run("R7");
    // R5 grant in the middle of a 7-idle gap
    d_gap = 3'd7; ack_at = 12; pkt(32'hC000_0000, 2, 0); run("R5");
    // R6 delay longer than the floor
    d_gap = 3'd1; d_den = 1; d_n = 4'd12; ack_at = 4; pkt(32'hD000_0000, 2, 0); run("R6");
    // R6 zero delay acts as disabled
    d_gap = 3'd3; d_n = 4'd0; ack_at = 5; pkt(32'hE000_0000, 1, 0); run("R6");
    // R9 R10 bubble in data, two packets back to back
    d_den = 0; d_gap = 3'd5; ack_at = 3;
    pkt(32'hF000_0000, 4, 1); pkt(32'h1234_0000, 2, 0); run("R9");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule